// File: doc/BRIEF.md
# Programmable Tap Divider Timer

This block is a sixteen-stage binary prescaler with a selectable output tap. It counts one-cycle count strobes inside a single clock domain. A two-bit selector picks which counter stage drives the output `timerOut`. The output can then run as a continuous power-of-two divider, or it can act as a one-shot that flips once after half a period and then holds. A polarity input sets the output level that the block shows while in reset, and every other output level is taken relative to that level.

The counter is built from two sections, a lower one and an upper one. All taps come from the upper section. The shortest division ratio skips the lower section and clocks the upper section directly from the strobe. The block can be initialised in three ways. A master reset clears it at any time. A power-up pulse clears it only when automatic reset is enabled. A change on the mode pin also clears it, one cycle after the change.

Top module: `tap_divider_timer`

## Requirements
- R1: The count advances only on a rising clock edge where `countStrobe` is 1 and no reset is active. Cycles without a strobe leave the next output transition exactly where it was.
- R2: `tapSel` selects the output stage. 2'b00 selects division by 8192, 2'b01 selects 1024, 2'b10 selects 256 and 2'b11 selects 65536. For a ratio of 2^n, the first output transition after reset comes after 2^(n-1) strobes.
- R3: With `tapSel` = 2'b10, the lower eight stages are frozen and the upper section counts every strobe. The output toggles every 128 strobes.
- R4: `masterReset` = 1 forces `timerOut` to the reset level in the same cycle and clears the count and the one-shot latch at the next edge. Counting restarts from zero once it is released.
- R5: `powerUpPulse` resets the block like `masterReset` only when `autoResetDisable` = 0. When `autoResetDisable` = 1 it has no effect on the output or the count.
- R6: While any reset is active, `timerOut` equals `polarity`.
- R7: With `recycleMode` = 1, `timerOut` equals the selected stage XOR `polarity`. It toggles every 2^(n-1) strobes and repeats with period 2^n.
- R8: With `recycleMode` = 0, `timerOut` stays at `polarity` until 2^(n-1) strobes have been counted. It then inverts and holds, even as counting continues past the period.
- R9: A change in the level of `recycleMode` causes an internal reset during the following cycle. `timerOut` equals `polarity` in that cycle, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| masterReset | input | 1 | Synchronous master reset, active high |
| autoResetDisable | input | 1 | 1 blocks the power-up pulse from resetting the block |
| powerUpPulse | input | 1 | Power-up reset request, active high |
| countStrobe | input | 1 | One-cycle count enable |
| tapSel | input | 2 | Division ratio select |
| recycleMode | input | 1 | 1 selects continuous division, 0 selects one-shot |
| polarity | input | 1 | Output level during reset |
| timerOut | output | 1 | Timer output |

## Verification
`timerOut` is decoded combinationally from registers. A strobe sampled at edge k therefore shows on the output right after edge k. A master reset or an enabled power-up pulse forces the output in the same cycle and clears the count at the next edge. A mode change forces the output one full cycle after the pin moves. The bench changes its inputs 2 ns after each rising edge. It updates a behavioural strobe-count model on the rising edge and compares the model with the output on every falling edge. Each directed check is placed at the falling edge that follows the exact strobe count it targets.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

  localparam int LOW_STAGES  = 8;
  localparam int HIGH_STAGES = 8;

  typedef struct packed {
    logic clear;      // reset the count and the one-shot latch at the next edge
    logic advance;    // count this edge
    logic bypassLow;  // upper section counts the strobe directly
    logic recycle;    // continuous division instead of one-shot
  } tap_strobe_t;

  // Counter stage (1-based) reached by each select code
  function automatic int stageFor(input logic [1:0] code);
    case (code)
      2'b00:   return 13;
      2'b01:   return 10;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/tap_timer_ctrl.sv
module tap_timer_ctrl
  import tap_timer_pkg::*;
#(
  parameter int LOW_W  = LOW_STAGES,
  parameter int HIGH_W = HIGH_STAGES,
  localparam int IDX_W = (HIGH_W > 1) ? $clog2(HIGH_W) : 1
) (
  input  logic              clk,
  input  logic              masterReset,
  input  logic              autoResetDisable,
  input  logic              powerUpPulse,
  input  logic              countStrobe,
  input  logic [1:0]        tapSel,
  input  logic              recycleMode,
  output tap_strobe_t       strb,
  output logic [IDX_W-1:0]  tapIdx
);

  logic hardReset;
  logic modeQ;
  logic modeRst;
  int   stageNum;
  logic bypass;

  assign hardReset = masterReset | (powerUpPulse & ~autoResetDisable);

  // Mode-pin edge detector: a level change becomes a one-cycle reset
  always_ff @(posedge clk) begin
    if (hardReset) begin
      modeQ   <= recycleMode;
      modeRst <= 1'b0;
    end else begin
      modeQ   <= recycleMode;
      modeRst <= (recycleMode != modeQ);
    end
  end

  always_comb begin
    stageNum = stageFor(tapSel);
    bypass   = (stageNum <= HIGH_W);
    if (bypass) tapIdx = IDX_W'(stageNum - 1);
    else        tapIdx = IDX_W'(stageNum - 1 - LOW_W);
  end

  always_comb begin
    strb.clear     = hardReset | modeRst;
    strb.advance   = countStrobe & ~strb.clear;
    strb.bypassLow = bypass;
    strb.recycle   = recycleMode;
  end

  AST_MODE_FLIP_RESET: assert property (@(posedge clk) disable iff (masterReset)
    (!hardReset && recycleMode != modeQ) |=> strb.clear); // R9

endmodule

// File: rtl/tap_timer_datapath.sv
module tap_timer_datapath
  import tap_timer_pkg::*;
#(
  parameter int LOW_W  = LOW_STAGES,
  parameter int HIGH_W = HIGH_STAGES,
  localparam int IDX_W = (HIGH_W > 1) ? $clog2(HIGH_W) : 1
) (
  input  logic              clk,
  input  tap_strobe_t       strb,
  input  logic [IDX_W-1:0]  tapIdx,
  input  logic              polarity,
  output logic              timerOut
);

  logic [HIGH_W-1:0] highCnt;
  logic              lowWrap;
  logic              fired;
  logic              tapBit;
  logic              shaped;
  logic              highStep;

  generate
    if (LOW_W > 0) begin : gLow
      logic [LOW_W-1:0] lowCnt;

      always_ff @(posedge clk) begin
        if (strb.clear)                          lowCnt <= '0;
        else if (strb.advance && !strb.bypassLow) lowCnt <= lowCnt + 1'b1;
      end

      assign lowWrap = &lowCnt;

      AST_LOW_FROZEN_IN_BYPASS: assert property (@(posedge clk) disable iff (strb.clear)
        strb.bypassLow |=> $stable(lowCnt)); // R3
      AST_LOW_CLEARED: assert property (@(posedge clk) disable iff (strb.clear)
        $past(strb.clear) |-> (lowCnt == '0)); // R4
      AST_LOW_IDLE_HOLDS: assert property (@(posedge clk) disable iff (strb.clear)
        !strb.advance |=> $stable(lowCnt)); // R1
    end else begin : gNoLow
      assign lowWrap = 1'b1;
    end
  endgenerate

  assign highStep = strb.advance & (strb.bypassLow | lowWrap);

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      highCnt <= '0;
      fired   <= 1'b0;
    end else begin
      if (highStep) highCnt <= highCnt + 1'b1;
      if (tapBit)   fired   <= 1'b1;
    end
  end

  assign tapBit   = highCnt[tapIdx];
  assign shaped   = strb.recycle ? tapBit : (fired | tapBit);
  assign timerOut = strb.clear ? polarity : (shaped ^ polarity);

  AST_HIGH_CLEARED: assert property (@(posedge clk) disable iff (strb.clear)
    $past(strb.clear) |-> (highCnt == '0 && !fired)); // R4
  AST_HIGH_IDLE_HOLDS: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.advance |=> $stable(highCnt)); // R1
  AST_ONESHOT_HOLDS: assert property (@(posedge clk) disable iff (strb.clear)
    fired |=> fired); // R8

endmodule

// File: rtl/tap_divider_timer.sv
module tap_divider_timer
  import tap_timer_pkg::*;
#(
  parameter int LOW_W  = LOW_STAGES,
  parameter int HIGH_W = HIGH_STAGES
) (
  input  logic       clk,
  input  logic       masterReset,
  input  logic       autoResetDisable,
  input  logic       powerUpPulse,
  input  logic       countStrobe,
  input  logic [1:0] tapSel,
  input  logic       recycleMode,
  input  logic       polarity,
  output logic       timerOut
);

  localparam int IDX_W = (HIGH_W > 1) ? $clog2(HIGH_W) : 1;

  tap_strobe_t      strb;
  logic [IDX_W-1:0] tapIdx;

  tap_timer_ctrl #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) uCtrl (
    .clk              (clk),
    .masterReset      (masterReset),
    .autoResetDisable (autoResetDisable),
    .powerUpPulse     (powerUpPulse),
    .countStrobe      (countStrobe),
    .tapSel           (tapSel),
    .recycleMode      (recycleMode),
    .strb             (strb),
    .tapIdx           (tapIdx)
  );

  tap_timer_datapath #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) uPath (
    .clk      (clk),
    .strb     (strb),
    .tapIdx   (tapIdx),
    .polarity (polarity),
    .timerOut (timerOut)
  );

  always_ff @(posedge clk) begin
    if (masterReset) begin
      AST_RESET_LEVEL: assert (timerOut == polarity); // R6
    end
  end

endmodule

// File: tb/tap_divider_timer_test.sv
module tap_divider_timer_test;

  logic       clk = 1'b0;
  logic       masterReset = 1'b1;
  logic       autoResetDisable = 1'b0;
  logic       powerUpPulse = 1'b1;
  logic       countStrobe = 1'b0;
  logic [1:0] tapSel = 2'b10;
  logic       recycleMode = 1'b1;
  logic       polarity = 1'b0;
  logic       timerOut;

  int tests = 0;
  int fails = 0;
  logic chkOn = 1'b0;
  logic done = 1'b0;

  // behavioural model state
  int   mCount = 0;
  logic mPend = 1'b0;
  logic mPrev = 1'b1;

  always #4 clk = ~clk;

  tap_divider_timer uut (
    .clk(clk), .masterReset(masterReset), .autoResetDisable(autoResetDisable),
    .powerUpPulse(powerUpPulse), .countStrobe(countStrobe), .tapSel(tapSel),
    .recycleMode(recycleMode), .polarity(polarity), .timerOut(timerOut)
  );

  function automatic int ratioLog(input logic [1:0] code);
    case (code)
      2'b00: return 13;
      2'b01: return 10;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic inResetNow();
    return masterReset | (powerUpPulse & ~autoResetDisable) | mPend;
  endfunction

  function automatic logic expectedOut();
    int n, half, per;
    logic stage;
    n = ratioLog(tapSel);
    half = 1 << (n - 1);
    per = 1 << n;
    stage = ((mCount % per) >= half);
    if (inResetNow()) return polarity;
    if (recycleMode) return stage ^ polarity;
    return (mCount >= half) ^ polarity;
  endfunction

  always @(posedge clk) begin
    logic hard, rstNow;
    hard = masterReset | (powerUpPulse & ~autoResetDisable);
    rstNow = hard | mPend;
    if (hard) begin
      mPend = 1'b0;
    end else begin
      mPend = (recycleMode != mPrev);
    end
    mPrev = recycleMode;
    if (rstNow) mCount = 0;
    else if (countStrobe) mCount++;
  end

  // continuous comparison on every falling edge
  always @(negedge clk) begin
    if (chkOn && !done) begin
      logic e;
      string tag;
      e = expectedOut();
      tag = inResetNow() ? "R6" : (recycleMode ? "R7" : "R8");
      tests++;
      if (timerOut !== e) begin
        fails++;
        $display("FAIL %s cycle-compare: timerOut=%0b expected=%0b", tag, timerOut, e);
      end
    end
  end

  task automatic chk(input string tag, input logic exp);
    @(negedge clk);
    tests++;
    if (timerOut !== exp) begin
      fails++;
      $display("FAIL %s directed: timerOut=%0b expected=%0b", tag, timerOut, exp);
    end
  endtask

  task automatic afterEdge();
    @(posedge clk);
    #2;
  endtask

  task automatic strobes(input int k);
    countStrobe = 1'b1;
    repeat (k) @(posedge clk);
    #2;
    countStrobe = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) afterEdge();
  endtask

  task automatic restart(input logic [1:0] sel, input logic mode, input logic pol);
    masterReset = 1'b1;
    tapSel = sel;
    recycleMode = mode;
    polarity = pol;
    chk("R6", pol);
    afterEdge();
    masterReset = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: timerOut=%0b expected=finished", timerOut);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    chk("R6", 1'b0);                 // reset level, polarity 0
    powerUpPulse = 1'b0;
    masterReset = 1'b0;
    chkOn = 1'b1;

    // R3: short ratio, upper section counts strobes directly
    strobes(127); chk("R3", 1'b0);
    strobes(1);   chk("R3", 1'b1);
    strobes(128); chk("R3", 1'b0);

    // R2, R1, R7 for every select code, polarity 1
    for (int c = 0; c < 4; c++) begin
      int half;
      half = 1 << (ratioLog(2'(c)) - 1);
      restart(2'(c), 1'b1, 1'b1);
      strobes(half - 1);
      idle(20);
      chk("R1", 1'b1);
      strobes(1);    chk("R2", 1'b0);
      strobes(half); chk("R7", 1'b1);
    end

    // R8: one-shot flips once and holds past the period
    restart(2'b10, 1'b0, 1'b0);
    strobes(127); chk("R8", 1'b0);
    strobes(1);   chk("R8", 1'b1);
    strobes(300); chk("R8", 1'b1);

    // R5: power-up pulse ignored while automatic reset is disabled
    autoResetDisable = 1'b1;
    powerUpPulse = 1'b1;
    chk("R5", 1'b1);
    afterEdge();
    powerUpPulse = 1'b0;
    strobes(5); chk("R5", 1'b1);
    autoResetDisable = 1'b0;
    powerUpPulse = 1'b1;
    chk("R5", 1'b0);
    afterEdge();
    powerUpPulse = 1'b0;
    strobes(127); chk("R5", 1'b0);
    strobes(1);   chk("R5", 1'b1);

    // R9: mode change resets the next cycle
    recycleMode = 1'b1;
    afterEdge();
    chk("R9", 1'b0);
    afterEdge();
    strobes(127); chk("R9", 1'b0);
    strobes(1);   chk("R9", 1'b1);

    // R4: master reset mid-count
    polarity = 1'b1;
    restart(2'b01, 1'b1, 1'b1);
    strobes(60);
    masterReset = 1'b1;
    chk("R4", 1'b1);
    afterEdge();
    masterReset = 1'b0;
    strobes(511); chk("R4", 1'b1);
    strobes(1);   chk("R4", 1'b0);

    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule